// File: doc/BRIEF.md
# Multi-Cycle Processor Control Sequencer

This block is the control unit of a small load/store processor whose datapath shares one memory and one ALU across several clock cycles of each instruction. It is a Moore state machine: every datapath control signal depends only on the current state. The block advances one execution step per clock. The opcode comes from the instruction register, and the sequencer uses it only in the states that branch on it.

Every instruction starts with the same two steps. The first fetches the instruction and advances the PC. The second reads both source registers and computes a speculative branch target. The opcode then selects a path of its own, so one instruction takes 3 to 5 cycles. Loads take five, stores and register-register operations take four, and branches and jumps take three. An opcode the block does not recognise goes straight back to fetch, with no write enable raised. The datapath, the memory and the decoding of the R-type function field sit outside this block. The block instead gives a 2-bit ALU operation class: add, subtract, or use the function field.

Top module: `mcc_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, the outputs hold the fetch values (see R2). Reset acts at once, even in the middle of an instruction.
- R2: Fetch raises `mem_rd`, `ir_we` and `pc_we`. It drives `addr_sel`=0, `srca_sel`=0, `srcb_sel`=2'b01, `alu_cls`=2'b00 (add) and `pc_src`=2'b00. All other outputs are 0, and the next state is decode.
- R3: Decode drives `srca_sel`=0, `srcb_sel`=2'b11 and `alu_cls`=2'b00, with every enable at 0. It picks the next state from `opcode`: 6'b100011 load, 6'b101011 store, 6'b000000 R-type, 6'b000100 branch-on-equal, 6'b000010 jump.
- R4: A load runs fetch, decode, address, memory read and write-back, which is 5 cycles. The address step drives `srca_sel`=1, `srcb_sel`=2'b10 and add. The read step raises `mem_rd` with `addr_sel`=1. Write-back raises `reg_we` with `dst_sel`=0 and `wb_sel`=1.
- R5: A store runs fetch, decode, address and memory write, which is 4 cycles. The write step raises `mem_wr` with `addr_sel`=1.
- R6: An R-type instruction runs fetch, decode, execute and completion, which is 4 cycles. Execute drives `srca_sel`=1, `srcb_sel`=2'b00 and `alu_cls`=2'b10. Completion raises `reg_we` with `dst_sel`=1 and `wb_sel`=0. A change of `opcode` after decode has no effect on this path.
- R7: Branch-on-equal runs 3 cycles. Its last step drives `srca_sel`=1, `srcb_sel`=2'b00, `alu_cls`=2'b01 (subtract) and `pc_src`=2'b01, and raises `pc_we_cond`.
- R8: A jump runs 3 cycles. Its last step raises `pc_we` with `pc_src`=2'b10 and leaves all memory, register and ALU controls at 0.
- R9: An unrecognised opcode at decode sends the machine to fetch on the next clock, without raising any write enable.
- R10: Each final step (store write, R-type completion, load write-back, branch, jump) is followed on the next clock by fetch.
- R11: `mem_rd` and `mem_wr` are never high together. At most one of `mem_wr`, `reg_we`, `pc_we` and `pc_we_cond` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode field of the instruction register |
| mem_rd | output | 1 | Memory read enable |
| mem_wr | output | 1 | Memory write enable |
| addr_sel | output | 1 | Memory address source: 0 = PC, 1 = ALU result register |
| ir_we | output | 1 | Instruction register write enable |
| reg_we | output | 1 | Register file write enable |
| dst_sel | output | 1 | Destination register: 0 = rt, 1 = rd |
| wb_sel | output | 1 | Write-back data: 0 = ALU result, 1 = memory data register |
| srca_sel | output | 1 | ALU operand A: 0 = PC, 1 = register A |
| srcb_sel | output | 2 | ALU operand B: 00 = B, 01 = 4, 10 = immediate, 11 = shifted immediate |
| alu_cls | output | 2 | ALU operation class: 00 add, 01 subtract, 10 function field |
| pc_src | output | 2 | PC source: 00 = ALU, 01 = ALU result register, 10 = jump address |
| pc_we | output | 1 | Unconditional PC write |
| pc_we_cond | output | 1 | PC write when the ALU reports zero |

## Verification
The assertions assume that `opcode` is valid and steady in decode and in the address step. In the datapath this holds because the instruction register is written only in fetch. The bench keeps to this by setting `opcode` once per instruction before decode. It changes `opcode` in only one case: during an R-type execute step, where the sequencer must ignore it. Reset is dropped once in the middle of a load, to show that the return to fetch takes effect at once.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

  localparam int OPC_W = 6;

  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'b101011;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_JUMP  = 6'b000010;

  localparam logic [1:0] ALU_ADD  = 2'b00;
  localparam logic [1:0] ALU_SUB  = 2'b01;
  localparam logic [1:0] ALU_FUNC = 2'b10;

  localparam logic [1:0] SRCB_REG  = 2'b00;
  localparam logic [1:0] SRCB_FOUR = 2'b01;
  localparam logic [1:0] SRCB_IMM  = 2'b10;
  localparam logic [1:0] SRCB_IMM4 = 2'b11;

  localparam logic [1:0] PCS_ALU  = 2'b00;
  localparam logic [1:0] PCS_HOLD = 2'b01;
  localparam logic [1:0] PCS_JMP  = 2'b10;

  typedef enum logic [3:0] {
    ST_FETCH,
    ST_DECODE,
    ST_ADDR,
    ST_LDRD,
    ST_LDWB,
    ST_STWR,
    ST_EXEC,
    ST_RDONE,
    ST_BRANCH,
    ST_JUMP
  } mcc_state_e;

  typedef struct packed {
    logic       mem_rd;
    logic       mem_wr;
    logic       addr_sel;
    logic       ir_we;
    logic       reg_we;
    logic       dst_sel;
    logic       wb_sel;
    logic       srca_sel;
    logic [1:0] srcb_sel;
    logic [1:0] alu_cls;
    logic [1:0] pc_src;
    logic       pc_we;
    logic       pc_we_cond;
  } mcc_ctrl_t;

endpackage

// File: rtl/mcc_seq.sv
module mcc_seq
  import mcc_pkg::*;
#(
  parameter int OW = OPC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [OW-1:0] opcode,
  output mcc_state_e    state
);

  mcc_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_FETCH:  state_d = ST_DECODE;
      ST_DECODE: begin
        unique case (opcode)
          OPC_LOAD, OPC_STORE: state_d = ST_ADDR;
          OPC_RTYPE:           state_d = ST_EXEC;
          OPC_BEQ:             state_d = ST_BRANCH;
          OPC_JUMP:            state_d = ST_JUMP;
          default:             state_d = ST_FETCH;
        endcase
      end
      ST_ADDR:   state_d = (opcode == OPC_LOAD) ? ST_LDRD : ST_STWR;
      ST_LDRD:   state_d = ST_LDWB;
      ST_EXEC:   state_d = ST_RDONE;
      ST_LDWB, ST_STWR, ST_RDONE, ST_BRANCH, ST_JUMP: state_d = ST_FETCH;
      default:   state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_FETCH;
    else        state_q <= state_d;
  end

  assign state = state_q;

  logic known_op;
  assign known_op = (opcode == OPC_LOAD) || (opcode == OPC_STORE) ||
                    (opcode == OPC_RTYPE) || (opcode == OPC_BEQ) ||
                    (opcode == OPC_JUMP);

  assert_fetch_to_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_FETCH |=> state_q == ST_DECODE);

  assert_load_read_then_wb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_LDRD |=> state_q == ST_LDWB);

  assert_exec_then_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_EXEC |=> state_q == ST_RDONE);

  assert_unknown_op_refetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DECODE && !known_op) |=> state_q == ST_FETCH);

  assert_final_to_fetch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q inside {ST_LDWB, ST_STWR, ST_RDONE, ST_BRANCH, ST_JUMP})
      |=> state_q == ST_FETCH);

endmodule

// File: rtl/mcc_outdec.sv
module mcc_outdec
  import mcc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  mcc_state_e state,
  output mcc_ctrl_t  ctrl
);

  always_comb begin
    ctrl = '0;
    unique case (state)
      ST_FETCH: begin
        ctrl.mem_rd   = 1'b1;
        ctrl.addr_sel = 1'b0;
        ctrl.ir_we    = 1'b1;
        ctrl.srca_sel = 1'b0;
        ctrl.srcb_sel = SRCB_FOUR;
        ctrl.alu_cls  = ALU_ADD;
        ctrl.pc_src   = PCS_ALU;
        ctrl.pc_we    = 1'b1;
      end
      ST_DECODE: begin
        ctrl.srca_sel = 1'b0;
        ctrl.srcb_sel = SRCB_IMM4;
        ctrl.alu_cls  = ALU_ADD;
      end
      ST_ADDR: begin
        ctrl.srca_sel = 1'b1;
        ctrl.srcb_sel = SRCB_IMM;
        ctrl.alu_cls  = ALU_ADD;
      end
      ST_LDRD: begin
        ctrl.mem_rd   = 1'b1;
        ctrl.addr_sel = 1'b1;
      end
      ST_LDWB: begin
        ctrl.reg_we   = 1'b1;
        ctrl.dst_sel  = 1'b0;
        ctrl.wb_sel   = 1'b1;
      end
      ST_STWR: begin
        ctrl.mem_wr   = 1'b1;
        ctrl.addr_sel = 1'b1;
      end
      ST_EXEC: begin
        ctrl.srca_sel = 1'b1;
        ctrl.srcb_sel = SRCB_REG;
        ctrl.alu_cls  = ALU_FUNC;
      end
      ST_RDONE: begin
        ctrl.reg_we   = 1'b1;
        ctrl.dst_sel  = 1'b1;
        ctrl.wb_sel   = 1'b0;
      end
      ST_BRANCH: begin
        ctrl.srca_sel   = 1'b1;
        ctrl.srcb_sel   = SRCB_REG;
        ctrl.alu_cls    = ALU_SUB;
        ctrl.pc_src     = PCS_HOLD;
        ctrl.pc_we_cond = 1'b1;
      end
      ST_JUMP: begin
        ctrl.pc_src   = PCS_JMP;
        ctrl.pc_we    = 1'b1;
      end
      default: ctrl = '0;
    endcase
  end

  assert_mem_rw_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl.mem_rd && ctrl.mem_wr));

  assert_one_writer_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl.mem_wr, ctrl.reg_we, ctrl.pc_we, ctrl.pc_we_cond}));

  assert_ir_only_in_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.ir_we |=> !ctrl.ir_we);

endmodule

// File: rtl/mcc_ctrl.sv
module mcc_ctrl
  import mcc_pkg::*;
#(
  parameter int OW = OPC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [OW-1:0] opcode,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          addr_sel,
  output logic          ir_we,
  output logic          reg_we,
  output logic          dst_sel,
  output logic          wb_sel,
  output logic          srca_sel,
  output logic [1:0]    srcb_sel,
  output logic [1:0]    alu_cls,
  output logic [1:0]    pc_src,
  output logic          pc_we,
  output logic          pc_we_cond
);

  mcc_state_e state;
  mcc_ctrl_t  ctrl;

  mcc_seq #(.OW(OW)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .opcode (opcode),
    .state  (state)
  );

  mcc_outdec u_dec (
    .clk   (clk),
    .rst_n (rst_n),
    .state (state),
    .ctrl  (ctrl)
  );

  assign mem_rd     = ctrl.mem_rd;
  assign mem_wr     = ctrl.mem_wr;
  assign addr_sel   = ctrl.addr_sel;
  assign ir_we      = ctrl.ir_we;
  assign reg_we     = ctrl.reg_we;
  assign dst_sel    = ctrl.dst_sel;
  assign wb_sel     = ctrl.wb_sel;
  assign srca_sel   = ctrl.srca_sel;
  assign srcb_sel   = ctrl.srcb_sel;
  assign alu_cls    = ctrl.alu_cls;
  assign pc_src     = ctrl.pc_src;
  assign pc_we      = ctrl.pc_we;
  assign pc_we_cond = ctrl.pc_we_cond;

  assert_store_write_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> (ir_we && mem_rd));

  assert_branch_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we_cond |=> ir_we);

endmodule

// File: tb/sim_mcc_ctrl.sv
module sim_mcc_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] opcode;
  logic       mem_rd, mem_wr, addr_sel, ir_we, reg_we, dst_sel, wb_sel, srca_sel;
  logic [1:0] srcb_sel, alu_cls, pc_src;
  logic       pc_we, pc_we_cond;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mcc_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .opcode(opcode),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .addr_sel(addr_sel), .ir_we(ir_we),
    .reg_we(reg_we), .dst_sel(dst_sel), .wb_sel(wb_sel), .srca_sel(srca_sel),
    .srcb_sel(srcb_sel), .alu_cls(alu_cls), .pc_src(pc_src),
    .pc_we(pc_we), .pc_we_cond(pc_we_cond)
  );

  logic [15:0] obs;
  assign obs = {mem_rd, mem_wr, addr_sel, ir_we, reg_we, dst_sel, wb_sel, srca_sel,
                srcb_sel, alu_cls, pc_src, pc_we, pc_we_cond};

  // Expected control words per step, bit order as in obs
  localparam logic [15:0] W_F  = 16'h9042;
  localparam logic [15:0] W_D  = 16'h00C0;
  localparam logic [15:0] W_MA = 16'h0180;
  localparam logic [15:0] W_MR = 16'hA000;
  localparam logic [15:0] W_WB = 16'h0A00;
  localparam logic [15:0] W_MW = 16'h6000;
  localparam logic [15:0] W_EX = 16'h0120;
  localparam logic [15:0] W_RC = 16'h0C00;
  localparam logic [15:0] W_BR = 16'h0115;
  localparam logic [15:0] W_J  = 16'h000A;

  localparam logic [5:0] O_LD = 6'b100011;
  localparam logic [5:0] O_ST = 6'b101011;
  localparam logic [5:0] O_R  = 6'b000000;
  localparam logic [5:0] O_BQ = 6'b000100;
  localparam logic [5:0] O_JP = 6'b000010;
  localparam logic [5:0] O_XX = 6'b111111;

  // Row: {requirement number, opcode, expected word}
  localparam int NV = 22;
  localparam logic [25:0] VEC [NV] = '{
    {4'd2,  O_LD, W_F }, {4'd3,  O_LD, W_D }, {4'd4,  O_LD, W_MA}, // R2 R3 R4
    {4'd4,  O_LD, W_MR}, {4'd4,  O_LD, W_WB},                      // R4
    {4'd10, O_ST, W_F }, {4'd3,  O_ST, W_D }, {4'd5,  O_ST, W_MA}, // R10 R5
    {4'd5,  O_ST, W_MW},                                           // R5
    {4'd10, O_R,  W_F }, {4'd3,  O_R,  W_D }, {4'd6,  O_R,  W_EX}, // R6
    {4'd6,  O_R,  W_RC},
    {4'd10, O_BQ, W_F }, {4'd3,  O_BQ, W_D }, {4'd7,  O_BQ, W_BR}, // R7
    {4'd10, O_JP, W_F }, {4'd3,  O_JP, W_D }, {4'd8,  O_JP, W_J }, // R8
    {4'd10, O_XX, W_F }, {4'd9,  O_XX, W_D }, {4'd9,  O_XX, W_F }  // R9
  };

  task automatic chk(input logic [15:0] exp, input int req);
    checks++;
    if (obs !== exp) begin
      failures++;
      $display("FAIL R%0d: actual=%h expected=%h", req, obs, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n  = 1'b0;
    opcode = O_R;
    repeat (3) @(negedge clk);
    chk(W_F, 1);                       // R1: fetch values under reset
    rst_n = 1'b1;
    chk(W_F, 1);                       // R1: first cycle after release
    // Table walk: the row VEC[NV-1] leaves the machine in fetch again
    for (int i = 0; i < NV; i++) begin
      opcode = VEC[i][21:16];
      chk(VEC[i][15:0], int'(VEC[i][25:22]));
      step();
    end
    // Now in decode after the unknown-opcode refetch; check R9 returned to fetch path
    // Directed R6: opcode changes during execute are ignored
    opcode = O_R;
    chk(W_D, 3);
    step();
    chk(W_EX, 6);
    opcode = O_LD;
    step();
    chk(W_RC, 6);                      // R6: still completion, not a memory read
    step();
    chk(W_F, 10);                      // R10
    // Directed R1: reset in the middle of a load
    opcode = O_LD;
    step();
    step();
    chk(W_MA, 4);
    rst_n = 1'b0;
    #1;
    chk(W_F, 1);                       // R1: immediate return to fetch
    @(negedge clk);
    rst_n = 1'b1;
    chk(W_F, 1);
    step();
    chk(W_D, 1);                       // R1: sequence resumes from fetch
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule